// File: doc/BRIEF.md
# Strip-Mined Vector Address Sequencer

This block turns one vector memory command into a stream of element addresses, one per clock when nothing stalls. A command carries a base address, a total element count, a strip-size exponent, an addressing mode and an element size. The block cuts the elements into strips no longer than the strip size. The short leftover strip comes first, and every later strip is full. Each element address is then produced in unit-stride, constant-stride or indexed-gather form.

A per-element side stream feeds the block. Each item holds the element's mask bit and, in gather mode, its index. Every element takes exactly one side item. The output carries an enable copied from the mask, strip-start and strip-end markers, and the length of the strip the element belongs to, which plays the part of the vector-length register. A valid/ready handshake on the output lets a memory pipeline stall the sequencer. A one-cycle completion pulse follows the final element.

Top module: `vag_seq`

## Requirements
- R1: The strip size is MVL = 2^e, where e is `cfg_vl_log2`. When the count n is above MVL, the first strip has n mod MVL elements and every later strip has MVL elements. `out_first` marks the first element of each strip, `out_last` marks its final element, and `out_vl` gives the strip length on every element.
- R2: When n mod MVL is 0 and n > 0, every strip has MVL elements. When 0 < n < MVL, there is a single strip of n elements. When n = 0, no element is produced and `done` is high in the cycle after the start is accepted.
- R3: Mode 2'b00 (and the unused code 2'b11) is unit stride: element k has address base + k * 2^s, where s is `cfg_esz` (element size 1, 2, 4 or 8 bytes).
- R4: Mode 2'b01 is constant stride: element k has address base + k * stride. The stride is a two's-complement byte distance, and the sum wraps modulo 2^AW.
- R5: Mode 2'b10 is indexed gather: element k has address base + (index_k << s), where index_k is the unsigned `in_index` of the k-th side item.
- R6: Every element consumes exactly one side item, whatever its mask. `out_en` equals that item's `in_mask`. An element whose mask bit is 0 still gets its address slot.
- R7: While `out_valid` is high and `out_ready` is low, the output element stays unchanged, and no element is lost or duplicated.
- R8: `done` is high for exactly the cycle after the final element of the final strip is accepted. It is never high while an element is pending.
- R9: A `start` that arrives while a command is active or an element is pending is ignored. The running sequence is unaffected.
- R10: A `cfg_vl_log2` above the parameter MAX_VL_LOG2 (default 6) is treated as MAX_VL_LOG2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a command when idle |
| cfg_mode | input | 2 | 00 unit, 01 stride, 10 gather, 11 as unit |
| cfg_base | input | AW | Base byte address |
| cfg_stride | input | AW | Signed byte stride (stride mode) |
| cfg_esz | input | 2 | log2 of element size in bytes |
| cfg_len | input | CW | Total element count n |
| cfg_vl_log2 | input | LW | Strip-size exponent |
| in_valid | input | 1 | Side item present |
| in_ready | output | 1 | Side item taken on this edge |
| in_mask | input | 1 | Mask bit of the element |
| in_index | input | IW | Gather index of the element |
| out_valid | output | 1 | Element present |
| out_ready | input | 1 | Consumer accepts element |
| out_addr | output | AW | Element byte address |
| out_en | output | 1 | Element enable (mask) |
| out_first | output | 1 | First element of a strip |
| out_last | output | 1 | Last element of a strip |
| out_vl | output | CW | Length of the current strip |
| done | output | 1 | Command complete pulse |

## Verification
Two things can happen in the same cycle. A pending element can leave through the output while the next side item loads into the same register. The same edge can also end one strip and begin the next, so the strip-length and position state flips on the edge where the end-of-strip element is accepted. The bench provokes both by pairing an unbroken input stream with pseudo-random output backpressure, using strips as short as two elements. A scoreboard built from the count, strip size and mode checks that each accepted element has the right address, markers and strip length, with no gap or repeat, and that completion comes exactly one cycle after the final acceptance.

// File: rtl/vag_pkg.sv
package vag_pkg;
    typedef enum logic [1:0] {
        VM_UNIT   = 2'b00,
        VM_STRIDE = 2'b01,
        VM_GATHER = 2'b10,
        VM_RSVD   = 2'b11
    } vmode_e;
endpackage

// File: rtl/vag_strip_plan.sv
module vag_strip_plan #(
    parameter int CW          = 16,
    parameter int LW          = 3,
    parameter int MAX_VL_LOG2 = 6
) (
    input  logic [CW-1:0] len,
    input  logic [LW-1:0] vl_log2,
    output logic [CW-1:0] mvl,
    output logic [CW-1:0] first_len,
    output logic [CW-1:0] rest,
    output logic          empty
);
    localparam logic [LW-1:0] MAXE = LW'(MAX_VL_LOG2);

    logic [LW-1:0] eff;
    logic [CW-1:0] modv;

    always_comb begin
        eff       = (vl_log2 > MAXE) ? MAXE : vl_log2;
        mvl       = CW'(1) << eff;
        modv      = len & (mvl - CW'(1));
        empty     = (len == '0);
        first_len = (modv == '0) ? mvl : modv;
        rest      = empty ? '0 : (len - first_len);
    end
endmodule

// File: rtl/vag_addr_unit.sv
module vag_addr_unit
    import vag_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 16
) (
    input  logic [1:0]    mode,
    input  logic [1:0]    esz,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] stride,
    input  logic [IW-1:0] index,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] next_ptr
);
    logic [AW-1:0] step;
    logic [AW-1:0] scaled;

    always_comb begin
        scaled = AW'(index) << esz;
        step   = (vmode_e'(mode) == VM_STRIDE) ? stride : (AW'(1) << esz);
        addr   = (vmode_e'(mode) == VM_GATHER) ? (base + scaled) : ptr;
        next_ptr = ptr + step;
    end
endmodule

// File: rtl/vag_seq.sv
module vag_seq #(
    parameter int AW          = 32,
    parameter int CW          = 16,
    parameter int IW          = 16,
    parameter int LW          = 3,
    parameter int MAX_VL_LOG2 = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cfg_mode,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_stride,
    input  logic [1:0]    cfg_esz,
    input  logic [CW-1:0] cfg_len,
    input  logic [LW-1:0] cfg_vl_log2,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_mask,
    input  logic [IW-1:0] in_index,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_addr,
    output logic          out_en,
    output logic          out_first,
    output logic          out_last,
    output logic [CW-1:0] out_vl,
    output logic          done
);
    localparam logic [CW-1:0] MVL_CAP = CW'(1) << MAX_VL_LOG2;

    typedef struct packed {
        logic          active;
        logic [1:0]    mode;
        logic [1:0]    esz;
        logic [AW-1:0] base;
        logic [AW-1:0] stride;
        logic [AW-1:0] ptr;
        logic [CW-1:0] pos;
        logic [CW-1:0] slen;
        logic [CW-1:0] rem;
        logic [CW-1:0] mvl;
        logic          ov;
        logic [AW-1:0] oaddr;
        logic          oen;
        logic          ofirst;
        logic          olast;
        logic          ofinal;
        logic [CW-1:0] ovl;
        logic          done;
    } st_t;

    st_t st_d, st_q;

    logic [CW-1:0] pl_mvl, pl_first, pl_rest;
    logic          pl_empty;
    logic [AW-1:0] ag_addr, ag_next;
    logic          take, idle, at_end;

    vag_strip_plan #(.CW(CW), .LW(LW), .MAX_VL_LOG2(MAX_VL_LOG2)) u_plan (
        .len(cfg_len), .vl_log2(cfg_vl_log2),
        .mvl(pl_mvl), .first_len(pl_first), .rest(pl_rest), .empty(pl_empty)
    );

    vag_addr_unit #(.AW(AW), .IW(IW)) u_addr (
        .mode(st_q.mode), .esz(st_q.esz), .base(st_q.base), .ptr(st_q.ptr),
        .stride(st_q.stride), .index(in_index),
        .addr(ag_addr), .next_ptr(ag_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        idle      = !st_q.active && !st_q.ov;
        take      = st_q.active && in_valid && (!st_q.ov || out_ready);
        at_end    = (st_q.pos == st_q.slen - CW'(1));

        if (st_q.ov && out_ready) begin
            st_d.ov = 1'b0;
            if (st_q.olast && st_q.ofinal) st_d.done = 1'b1;
        end

        if (take) begin
            st_d.ov     = 1'b1;
            st_d.oaddr  = ag_addr;
            st_d.oen    = in_mask;
            st_d.ofirst = (st_q.pos == '0);
            st_d.olast  = at_end;
            st_d.ofinal = at_end && (st_q.rem == '0);
            st_d.ovl    = st_q.slen;
            st_d.ptr    = ag_next;
            if (at_end) begin
                st_d.pos = '0;
                if (st_q.rem == '0) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.slen = st_q.mvl;
                    st_d.rem  = st_q.rem - st_q.mvl;
                end
            end else begin
                st_d.pos = st_q.pos + CW'(1);
            end
        end

        if (start && idle) begin
            st_d.active = !pl_empty;
            st_d.mode   = cfg_mode;
            st_d.esz    = cfg_esz;
            st_d.base   = cfg_base;
            st_d.stride = cfg_stride;
            st_d.ptr    = cfg_base;
            st_d.pos    = '0;
            st_d.slen   = pl_first;
            st_d.rem    = pl_rest;
            st_d.mvl    = pl_mvl;
            if (pl_empty) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = st_q.active && (!st_q.ov || out_ready);
    assign out_valid = st_q.ov;
    assign out_addr  = st_q.oaddr;
    assign out_en    = st_q.oen;
    assign out_first = st_q.ofirst;
    assign out_last  = st_q.olast;
    assign out_vl    = st_q.ovl;
    assign done      = st_q.done;

    // R7: a stalled element must not change
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_en)
                                    && $stable(out_last) && $stable(out_vl));

    // R8: completion follows acceptance of the final element
    a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last && st_q.ofinal |=> done);

    // R8: no completion while an element is pending
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    // R1: strip length within the cap
    a_r1_vl_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_vl != '0) && (out_vl <= MVL_CAP));

    // R1: a one-element strip both opens and closes
    a_r1_single_strip: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_vl == CW'(1)) |-> out_first && out_last);
endmodule

// File: tb/tb_vag_seq.sv
module tb_vag_seq;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int IW = 16;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_stride = '0;
    logic [1:0]    cfg_esz = '0;
    logic [CW-1:0] cfg_len = '0;
    logic [LW-1:0] cfg_vl_log2 = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_mask = 1'b0;
    logic [IW-1:0] in_index = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [AW-1:0] out_addr;
    logic          out_en, out_first, out_last, done;
    logic [CW-1:0] out_vl;

    vag_seq dut (.*);

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [7:0] lf = 8'h5a;
    logic bp_on = 1'b0;
    logic due_next = 1'b0;

    logic [AW-1:0] q_addr[$];
    logic          q_en[$], q_first[$], q_last[$], q_fin[$];
    logic [CW-1:0] q_vl[$];
    string         q_tag[$];

    // backpressure source
    initial forever begin
        @(posedge clk); #1;
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        out_ready = bp_on ? (lf[0] | lf[2]) : 1'b1;
    end

    // watchdog
    initial forever begin
        @(posedge clk);
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // monitor / scoreboard
    logic          prev_stall = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    initial forever begin
        logic exp_done;
        @(negedge clk);
        if (rst_n) begin
            exp_done = due_next;
            due_next = 1'b0;
            if (done !== exp_done) begin
                total++; bad++;
                $display("FAIL R8 done: actual=%0b expected=%0b", done, exp_done);
            end else if (exp_done) total++;
            if (prev_stall) begin
                total++;
                if (!(out_valid && out_addr == prev_addr)) begin
                    bad++;
                    $display("FAIL R7 stall hold: actual=%0b/%h expected=1/%h",
                             out_valid, out_addr, prev_addr);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_addr  = out_addr;
            if (out_valid && out_ready) begin
                total++;
                if (q_addr.size() == 0) begin
                    bad++;
                    $display("FAIL R6 extra element: actual=%h expected=none", out_addr);
                end else begin
                    logic [AW-1:0] ea; logic ee, ef, el, efin; logic [CW-1:0] ev; string tg;
                    ea = q_addr.pop_front(); ee = q_en.pop_front(); ef = q_first.pop_front();
                    el = q_last.pop_front(); ev = q_vl.pop_front(); efin = q_fin.pop_front();
                    tg = q_tag.pop_front();
                    if (out_addr !== ea || out_en !== ee || out_first !== ef ||
                        out_last !== el || out_vl !== ev) begin
                        bad++;
                        $display("FAIL %s element: actual=%h en%0b f%0b l%0b vl%0d expected=%h en%0b f%0b l%0b vl%0d",
                                 tg, out_addr, out_en, out_first, out_last, out_vl,
                                 ea, ee, ef, el, ev);
                    end
                    if (efin) due_next = 1'b1;
                end
            end
        end
    end

    function automatic logic mask_of(int k, int seed);
        return ((k * 7 + seed) % 3) != 0;
    endfunction

    function automatic logic [IW-1:0] idx_of(int k, int seed);
        return IW'((k * 37 + seed * 11) % 1000);
    endfunction

    task automatic run_cmd(input logic [1:0] mode, input logic [AW-1:0] base,
                           input logic [AW-1:0] stride, input logic [1:0] esz,
                           input int n, input int l2, input int seed,
                           input bit inject, input string tag);
        int eff, mvl, slen, pos;
        eff  = (l2 > 6) ? 6 : l2;
        mvl  = 1 << eff;
        slen = n % mvl;
        if (slen == 0) slen = mvl;
        pos = 0;
        for (int k = 0; k < n; k++) begin
            logic [AW-1:0] a;
            if (mode == 2'b10)      a = base + (AW'(idx_of(k, seed)) << esz);
            else if (mode == 2'b01) a = base + AW'(k) * stride;
            else                    a = base + (AW'(k) << esz);
            q_addr.push_back(a);
            q_en.push_back(mask_of(k, seed));
            q_first.push_back(pos == 0);
            q_last.push_back(pos == slen - 1);
            q_vl.push_back(CW'(slen));
            q_fin.push_back(k == n - 1);
            q_tag.push_back(tag);
            if (pos == slen - 1) begin pos = 0; slen = mvl; end
            else pos++;
        end
        @(posedge clk); #1;
        cfg_mode = mode; cfg_base = base; cfg_stride = stride; cfg_esz = esz;
        cfg_len = CW'(n); cfg_vl_log2 = LW'(l2); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (n == 0) due_next = 1'b1;
        for (int k = 0; k < n; k++) begin
            logic got;
            if (k % 5 == 3) begin in_valid = 1'b0; @(posedge clk); #1; end
            in_valid = 1'b1; in_mask = mask_of(k, seed); in_index = idx_of(k, seed);
            forever begin
                @(negedge clk); got = in_ready;
                @(posedge clk); #1;
                if (got) break;
            end
            in_valid = 1'b0;
            if (inject && k == 2) begin
                // R9: start while busy, with different fields
                cfg_base = 32'hdead_0000; cfg_len = 16'd3; cfg_mode = 2'b10; start = 1'b1;
                @(posedge clk); #1;
                start = 1'b0;
            end
        end
        while (q_addr.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || done !== 1'b0 || in_ready !== 1'b0) begin
            bad++;
            $display("FAIL reset: actual=v%0b d%0b r%0b expected=0 0 0", out_valid, done, in_ready);
        end
        // R1/R3: 10 elements, strips 2,4,4, 4-byte unit stride
        run_cmd(2'b00, 32'h0000_1000, '0, 2'd2, 10, 2, 1, 1'b0, "R1/R3 unit");
        // R2/R4: 8 elements, strips 4,4, negative stride
        run_cmd(2'b01, 32'h0000_2000, -32'sd12, 2'd0, 8, 2, 2, 1'b0, "R2/R4 stride");
        // R5/R6: gather, single strip of 5, 8-byte elements
        run_cmd(2'b10, 32'h0004_0000, '0, 2'd3, 5, 3, 3, 1'b0, "R5/R6 gather");
        // R2: zero count
        run_cmd(2'b00, 32'h0000_3000, '0, 2'd0, 0, 2, 4, 1'b0, "R2 empty");
        // R10: exponent 7 clamped to 6, strips 2,64,64
        run_cmd(2'b00, 32'h0001_0000, '0, 2'd0, 130, 7, 5, 1'b0, "R10 clamp");
        bp_on = 1'b1;
        // R7 with backpressure, R9 start while busy, strips of 2
        run_cmd(2'b01, 32'h0000_8000, 32'd24, 2'd0, 7, 1, 6, 1'b1, "R7/R9 stride");
        run_cmd(2'b10, 32'h0000_0100, '0, 2'd1, 9, 2, 7, 1'b0, "R6/R7 gather");
        run_cmd(2'b11, 32'h0000_0040, '0, 2'd1, 6, 2, 8, 1'b0, "R3 reserved-mode");
        bp_on = 1'b0;
        repeat (4) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule